// File: doc/BRIEF.md
# Descriptor DMA Interrupt Coalescer with Inactivity Timer

This block produces the interrupt line of a descriptor-driven DMA engine. The engine reports each finished descriptor with a one-cycle pulse on `desc_done` and each started transfer with a one-cycle pulse on `xfer_start`. Completions are counted, and a completion event is recorded once the count reaches a programmable batch size. Grouping completions this way lets software take one interrupt per batch rather than one per descriptor.

A batch that stops short of the batch size would otherwise never be reported. A second source handles it: an inactivity timer, advanced by a prescaled `tick` input, records a delay event when no activity pulse has been seen for a programmed number of ticks. Both events land in sticky status bits. Software clears those bits by writing ones to them. The `irq` output is raised while any status bit is set and its enable bit is also set.

Software sees four word registers through a simple write port and a combinational read port. The register selected by address 0 is the control register, with bit 0 enabling the completion interrupt and bit 1 enabling the delay interrupt. Address 1 holds the batch size in bits [7:0]. Address 2 holds the inactivity count in bits [7:0]. Address 3 is status, with bit 0 as the completion event and bit 1 as the delay event. All bits that are not listed read as zero.

Top module: `dma_irq_coalesce`

## Requirements
- R1: After reset the batch size reads 1, the inactivity count reads 0, both enable bits read 0, both status bits read 0, and `irq` is low.
- R2: Status bit 0 sets in the cycle that the completion pulse bringing the running count up to the batch size is clocked. The running count then restarts from zero, and fewer completions leave the bit clear.
- R3: A write of 0 to the batch-size register is stored as 1, and the batch size never reads as 0.
- R4: A write to the batch-size register clears the running completion count. A completion pulse in the same cycle as that write is not counted.
- R5: Any `desc_done` or `xfer_start` pulse reloads the inactivity timer with the programmed count N. Only `tick` pulses advance the timer. Status bit 1 sets on the Nth tick that arrives with no activity pulse in between, and the timer then stays idle until the next activity pulse.
- R6: While the inactivity count is 0, the timer does not run and status bit 1 never sets.
- R7: Status bits are sticky. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a new event and a clear for the same bit arrive in the same cycle, the event wins and the bit ends set.
- R8: `irq` equals (status bit 0 AND control bit 0) OR (status bit 1 AND control bit 1). Status bits keep recording events while their enables are clear.
- R9: A partial batch is one that ends with fewer completions than the batch size and is followed by silence. It sets status bit 1 after N ticks and does not set status bit 0.
- R10: A write to the inactivity-count register stops a running timer. The timer waits for the next activity pulse before it counts with the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_done | input | 1 | One-cycle pulse per completed descriptor |
| xfer_start | input | 1 | One-cycle pulse per started transfer |
| tick | input | 1 | Prescaled timebase pulse for the inactivity timer |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Write register select |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 2 | Read register select |
| reg_rdata | output | 32 | Read data (combinational) |
| irq | output | 1 | Combined interrupt request |

## Verification
On every cycle, the assertions check several invariants. The batch size is never zero. The running count stays below the batch size and is zero in the cycle after a batch-size write. The timer is idle whenever the inactivity count is zero, and an armed timer holds a value in the range 1 to N. A status bit never drops without a write-one to that bit. A completion event only follows a `desc_done` pulse, and `irq` stays low while both enables are clear. The bench's scenarios cover the things a single-cycle property cannot show. These include the exact tick on which the delay event fires, a reload in the middle of a countdown, a partial batch being reported by the timer, a batch-size write discarding a partial count, and the set-over-clear collision.

// File: rtl/irq_coal_pkg.sv
package irq_coal_pkg;

    localparam int THR_W  = 8;
    localparam int DLY_W  = 8;
    localparam int REG_DW = 32;
    localparam int REG_AW = 2;

    typedef enum logic [REG_AW-1:0] {
        SEL_CTRL   = 2'd0,
        SEL_THRESH = 2'd1,
        SEL_DELAY  = 2'd2,
        SEL_STATUS = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic dly;
        logic cmpl;
    } irq_bits_t;

endpackage

// File: rtl/irq_coal_regs.sv
module irq_coal_regs
    import irq_coal_pkg::*;
#(
    parameter int TW = THR_W,
    parameter int DW = DLY_W,
    parameter int RW = REG_DW
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [1:0]      wr_addr,
    input  logic [RW-1:0]   wr_data,
    input  logic [1:0]      rd_addr,
    output logic [RW-1:0]   rd_data,
    input  irq_bits_t       set_in,
    output irq_bits_t       en_q,
    output irq_bits_t       sts_q,
    output logic [TW-1:0]   thr_q,
    output logic [DW-1:0]   dly_q,
    output logic            thr_wr,
    output logic            dly_wr
);

    reg_sel_e  wsel;
    reg_sel_e  rsel;
    irq_bits_t clr;
    logic [TW-1:0] thr_in;
    logic unused_wdata;

    assign wsel   = reg_sel_e'(wr_addr);
    assign rsel   = reg_sel_e'(rd_addr);
    assign thr_wr = wr_en && (wsel == SEL_THRESH);
    assign dly_wr = wr_en && (wsel == SEL_DELAY);
    assign thr_in = (wr_data[TW-1:0] == '0) ? TW'(1) : wr_data[TW-1:0];
    assign unused_wdata = ^wr_data;

    always_comb begin
        clr = '0;
        if (wr_en && (wsel == SEL_STATUS)) begin
            clr.cmpl = wr_data[0];
            clr.dly  = wr_data[1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            sts_q <= '0;
            thr_q <= TW'(1);
            dly_q <= '0;
        end else begin
            sts_q.cmpl <= (sts_q.cmpl & ~clr.cmpl) | set_in.cmpl;
            sts_q.dly  <= (sts_q.dly  & ~clr.dly)  | set_in.dly;
            if (wr_en && (wsel == SEL_CTRL)) begin
                en_q.cmpl <= wr_data[0];
                en_q.dly  <= wr_data[1];
            end
            if (thr_wr) thr_q <= thr_in;
            if (dly_wr) dly_q <= wr_data[DW-1:0];
        end
    end

    always_comb begin
        rd_data = '0;
        case (rsel)
            SEL_CTRL:   rd_data[1:0]    = en_q;
            SEL_THRESH: rd_data[TW-1:0] = thr_q;
            SEL_DELAY:  rd_data[DW-1:0] = dly_q;
            SEL_STATUS: rd_data[1:0]    = sts_q;
            default:    rd_data         = '0;
        endcase
    end

endmodule

// File: rtl/irq_coal_count.sv
module irq_coal_count #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          done,
    input  logic [TW-1:0] thr,
    input  logic          thr_wr,
    output logic [TW-1:0] cnt_q,
    output logic          fire
);

    localparam int EW = TW + 1;

    logic [TW-1:0] cnt_d;
    logic [EW-1:0] cnt_inc;

    assign cnt_inc = {1'b0, cnt_q} + EW'(1);

    always_comb begin
        cnt_d = cnt_q;
        fire  = 1'b0;
        if (thr_wr) begin
            cnt_d = '0;
        end else if (done) begin
            if (cnt_inc >= {1'b0, thr}) begin
                cnt_d = '0;
                fire  = 1'b1;
            end else begin
                cnt_d = cnt_inc[TW-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

endmodule

// File: rtl/irq_coal_delay.sv
module irq_coal_delay #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          activity,
    input  logic          tick,
    input  logic [DW-1:0] dly,
    input  logic          dly_wr,
    output logic          armed_q,
    output logic [DW-1:0] val_q,
    output logic          fire
);

    logic          armed_d;
    logic [DW-1:0] val_d;

    always_comb begin
        armed_d = armed_q;
        val_d   = val_q;
        fire    = 1'b0;
        if (dly_wr) begin
            armed_d = 1'b0;
            val_d   = '0;
        end else if (activity) begin
            val_d   = dly;
            armed_d = (dly != '0);
        end else if (armed_q && tick) begin
            if (val_q == DW'(1)) begin
                fire    = 1'b1;
                armed_d = 1'b0;
                val_d   = '0;
            end else begin
                val_d = val_q - DW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            val_q   <= '0;
        end else begin
            armed_q <= armed_d;
            val_q   <= val_d;
        end
    end

endmodule

// File: rtl/dma_irq_coalesce.sv
module dma_irq_coalesce
    import irq_coal_pkg::*;
#(
    parameter int THR_BITS = THR_W,
    parameter int DLY_BITS = DLY_W,
    parameter int DATA_W   = REG_DW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              desc_done,
    input  logic              xfer_start,
    input  logic              tick,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [1:0]        reg_raddr,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);

    irq_bits_t           en_q;
    irq_bits_t           sts_q;
    irq_bits_t           set_in;
    logic [THR_BITS-1:0] thr_q;
    logic [THR_BITS-1:0] cnt_q;
    logic [DLY_BITS-1:0] dly_q;
    logic [DLY_BITS-1:0] tmr_val;
    logic                tmr_armed;
    logic                thr_wr;
    logic                dly_wr;
    logic                cmpl_fire;
    logic                dly_fire;

    irq_coal_regs #(.TW(THR_BITS), .DW(DLY_BITS), .RW(DATA_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr),
        .wr_addr (reg_addr),
        .wr_data (reg_wdata),
        .rd_addr (reg_raddr),
        .rd_data (reg_rdata),
        .set_in  (set_in),
        .en_q    (en_q),
        .sts_q   (sts_q),
        .thr_q   (thr_q),
        .dly_q   (dly_q),
        .thr_wr  (thr_wr),
        .dly_wr  (dly_wr)
    );

    irq_coal_count #(.TW(THR_BITS)) u_count (
        .clk    (clk),
        .rst    (rst),
        .done   (desc_done),
        .thr    (thr_q),
        .thr_wr (thr_wr),
        .cnt_q  (cnt_q),
        .fire   (cmpl_fire)
    );

    irq_coal_delay #(.DW(DLY_BITS)) u_delay (
        .clk      (clk),
        .rst      (rst),
        .activity (desc_done | xfer_start),
        .tick     (tick),
        .dly      (dly_q),
        .dly_wr   (dly_wr),
        .armed_q  (tmr_armed),
        .val_q    (tmr_val),
        .fire     (dly_fire)
    );

    assign set_in.cmpl = cmpl_fire;
    assign set_in.dly  = dly_fire;
    assign irq = (sts_q.cmpl & en_q.cmpl) | (sts_q.dly & en_q.dly);

endmodule

// File: rtl/irq_coal_chk.sv
module irq_coal_chk #(
    parameter int TW = 8,
    parameter int DW = 8,
    parameter int RW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          desc_done,
    input logic          reg_wr,
    input logic [1:0]    reg_addr,
    input logic [RW-1:0] reg_wdata,
    input logic          irq,
    input logic [1:0]    en_q,
    input logic [1:0]    sts_q,
    input logic [TW-1:0] thr_q,
    input logic [TW-1:0] cnt_q,
    input logic [DW-1:0] dly_q,
    input logic          tmr_armed,
    input logic [DW-1:0] tmr_val
);

    assert_thr_nonzero_R3: assert property (@(posedge clk) disable iff (rst)
        thr_q != '0);

    assert_cnt_below_thr_R2: assert property (@(posedge clk) disable iff (rst)
        cnt_q < thr_q);

    assert_cmpl_after_done_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(sts_q[0]) |-> $past(desc_done));

    assert_thr_write_clears_R4: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd1) |=> (cnt_q == '0));

    assert_timer_range_R5: assert property (@(posedge clk) disable iff (rst)
        tmr_armed |-> (tmr_val != '0 && tmr_val <= dly_q));

    assert_timer_off_R6: assert property (@(posedge clk) disable iff (rst)
        (dly_q == '0) |-> !tmr_armed);

    assert_sticky_cmpl_R7: assert property (@(posedge clk) disable iff (rst)
        (sts_q[0] && !(reg_wr && reg_addr == 2'd3 && reg_wdata[0])) |=> sts_q[0]);

    assert_sticky_dly_R7: assert property (@(posedge clk) disable iff (rst)
        (sts_q[1] && !(reg_wr && reg_addr == 2'd3 && reg_wdata[1])) |=> sts_q[1]);

    assert_irq_masked_R8: assert property (@(posedge clk) disable iff (rst)
        (en_q == 2'b00) |-> !irq);

endmodule

bind dma_irq_coalesce irq_coal_chk #(.TW(THR_BITS), .DW(DLY_BITS), .RW(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .desc_done (desc_done),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .irq       (irq),
    .en_q      (en_q),
    .sts_q     (sts_q),
    .thr_q     (thr_q),
    .cnt_q     (cnt_q),
    .dly_q     (dly_q),
    .tmr_armed (tmr_armed),
    .tmr_val   (tmr_val)
);

// File: tb/tb_dma_irq_coalesce.sv
module tb_dma_irq_coalesce;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        desc_done = 1'b0;
    logic        xfer_start = 1'b0;
    logic        tick = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [1:0]  reg_raddr = 2'd0;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // behavioural reference state
    int m_thr, m_dly, m_cnt, m_left;
    bit m_armed, m_en_c, m_en_d, m_st_c, m_st_d, m_cf, m_df;

    always #5 clk = ~clk;

    dma_irq_coalesce dut (
        .clk(clk), .rst(rst), .desc_done(desc_done), .xfer_start(xfer_start),
        .tick(tick), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_raddr(reg_raddr), .reg_rdata(reg_rdata), .irq(irq)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_thr = 1; m_dly = 0; m_cnt = 0; m_left = 0; m_armed = 0;
            m_en_c = 0; m_en_d = 0; m_st_c = 0; m_st_d = 0;
        end else begin
            m_cf = 0; m_df = 0;
            if (reg_wr && reg_addr == 2'd1) m_cnt = 0;
            else if (desc_done) begin
                m_cnt = m_cnt + 1;
                if (m_cnt >= m_thr) begin m_cnt = 0; m_cf = 1; end
            end
            if (reg_wr && reg_addr == 2'd2) m_armed = 0;
            else if (desc_done || xfer_start) begin
                m_left = m_dly; m_armed = (m_dly != 0);
            end else if (m_armed && tick) begin
                m_left = m_left - 1;
                if (m_left == 0) begin m_df = 1; m_armed = 0; end
            end
            if (reg_wr && reg_addr == 2'd3) begin
                if (reg_wdata[0]) m_st_c = 0;
                if (reg_wdata[1]) m_st_d = 0;
            end
            if (m_cf) m_st_c = 1;
            if (m_df) m_st_d = 1;
            if (reg_wr && reg_addr == 2'd0) begin m_en_c = reg_wdata[0]; m_en_d = reg_wdata[1]; end
            if (reg_wr && reg_addr == 2'd1) m_thr = (reg_wdata[7:0] == 0) ? 1 : int'(reg_wdata[7:0]);
            if (reg_wr && reg_addr == 2'd2) m_dly = int'(reg_wdata[7:0]);
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_rd(input logic [1:0] a);
        case (a)
            2'd0: return {30'd0, m_en_d, m_en_c};
            2'd1: return 32'(m_thr);
            2'd2: return 32'(m_dly);
            default: return {30'd0, m_st_d, m_st_c};
        endcase
    endfunction

    function automatic string rd_tag(input logic [1:0] a);
        case (a)
            2'd0: return "R8 ctrl";
            2'd1: return "R3 thresh";
            2'd2: return "R5 delay";
            default: return "R7 status";
        endcase
    endfunction

    // one cycle: compare against the model at the falling edge, then drive
    task automatic cyc(input bit d, input bit s, input bit t, input bit w,
                       input logic [1:0] a, input logic [31:0] v);
        @(negedge clk);
        if (!rst) begin
            chk("R8 irq", {31'd0, irq}, {31'd0, (m_st_c & m_en_c) | (m_st_d & m_en_d)});
            chk(rd_tag(reg_raddr), reg_rdata, model_rd(reg_raddr));
        end
        desc_done = d; xfer_start = s; tick = t; reg_wr = w; reg_addr = a; reg_wdata = v;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 2'd0, 32'd0);
    endtask
    task automatic wreg(input logic [1:0] a, input logic [31:0] v);
        cyc(0, 0, 0, 1, a, v); idle(1);
    endtask
    task automatic done1();  cyc(1, 0, 0, 0, 2'd0, 32'd0); idle(1); endtask
    task automatic start1(); cyc(0, 1, 0, 0, 2'd0, 32'd0); idle(1); endtask
    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin cyc(0, 0, 1, 0, 2'd0, 32'd0); idle(2); end
    endtask
    task automatic peek(input logic [1:0] a, input logic [31:0] e, input string tag);
        reg_raddr = a; #1; chk(tag, reg_rdata, e);
    endtask

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);
        // R1 reset values
        peek(2'd0, 32'd0, "R1 ctrl");
        peek(2'd1, 32'd1, "R1 thresh");
        peek(2'd2, 32'd0, "R1 delay");
        peek(2'd3, 32'd0, "R1 status");
        chk("R1 irq", {31'd0, irq}, 32'd0);

        // R2 default batch size of one, R8 irq follows enable
        wreg(2'd0, 32'd1);
        done1();
        peek(2'd3, 32'd1, "R2 single completion");
        chk("R8 irq on", {31'd0, irq}, 32'd1);
        // R7 write zero keeps, write one clears
        wreg(2'd3, 32'd0);
        peek(2'd3, 32'd1, "R7 write zero keeps");
        wreg(2'd3, 32'd1);
        peek(2'd3, 32'd0, "R7 write one clears");

        // R2 batch of three
        wreg(2'd1, 32'd3);
        done1(); done1();
        peek(2'd3, 32'd0, "R2 below batch");
        done1();
        peek(2'd3, 32'd1, "R2 batch reached");
        wreg(2'd3, 32'd3);
        done1(); done1();
        peek(2'd3, 32'd0, "R2 count restarted");

        // R4 threshold write discards partial count
        wreg(2'd1, 32'd3);
        done1(); done1();
        peek(2'd3, 32'd0, "R4 after rewrite");
        cyc(1, 0, 0, 1, 2'd1, 32'd3); idle(1);
        done1(); done1();
        peek(2'd3, 32'd0, "R4 collision not counted");
        done1();
        peek(2'd3, 32'd1, "R4 third after rewrite");
        wreg(2'd3, 32'd3);

        // R3 zero batch size stored as one
        wreg(2'd1, 32'd0);
        peek(2'd1, 32'd1, "R3 zero becomes one");

        // R5 delay fires on the Nth tick
        wreg(2'd0, 32'd3);
        wreg(2'd2, 32'd4);
        start1();
        ticks(3);
        peek(2'd3, 32'd0, "R5 before Nth tick");
        idle(10);
        peek(2'd3, 32'd0, "R5 clocks alone do not advance");
        ticks(1);
        peek(2'd3, 32'd2, "R5 Nth tick fires");
        wreg(2'd3, 32'd3);
        ticks(6);
        peek(2'd3, 32'd0, "R5 idle after firing");
        // R5 reload by a completion
        start1();
        ticks(3);
        done1();
        ticks(3);
        peek(2'd3, 32'd1, "R5 reload postpones");
        ticks(1);
        peek(2'd3, 32'd3, "R5 fires after reload");
        chk("R8 both enabled", {31'd0, irq}, 32'd1);
        wreg(2'd3, 32'd3);

        // R9 partial batch reported by the timer
        wreg(2'd1, 32'd3);
        wreg(2'd2, 32'd2);
        done1(); done1();
        ticks(2);
        peek(2'd3, 32'd2, "R9 partial batch");
        wreg(2'd3, 32'd3);

        // R6 zero delay never fires
        wreg(2'd2, 32'd0);
        start1();
        ticks(300);
        peek(2'd3, 32'd0, "R6 disabled timer");

        // R10 delay write stops countdown
        wreg(2'd2, 32'd5);
        start1();
        ticks(2);
        wreg(2'd2, 32'd5);
        ticks(10);
        peek(2'd3, 32'd0, "R10 write stops timer");

        // R7 set wins over clear
        wreg(2'd1, 32'd1);
        done1();
        cyc(1, 0, 0, 1, 2'd3, 32'd1); idle(1);
        peek(2'd3, 32'd1, "R7 set beats clear");

        // R8 masking
        wreg(2'd0, 32'd0);
        chk("R8 masked", {31'd0, irq}, 32'd0);
        wreg(2'd0, 32'd2);
        chk("R8 other enable", {31'd0, irq}, 32'd0);
        wreg(2'd0, 32'd1);
        chk("R8 matching enable", {31'd0, irq}, 32'd1);
        peek(2'd3, 32'd1, "R8 status kept while masked");

        idle(2);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule